// File: doc/BRIEF.md
# Free-Running Timer with Sticky Overflow Flag

This block is a free-running up-counter with two channel registers and an 8-bit option register. The counter advances by one on every clock while the count enable is high and is held at zero while the enable is low. When the counter wraps from all-ones to zero in free-running or pulse-width mode, a sticky overflow flag is set and a one-cycle interrupt pulse is raised. Hardware sets the flag. Software can clear it but never set it. Dropping the count enable also clears it.

Each channel register is a capture register or a compare register, chosen by a select bit in the option register. Capture takes effect only in free-running mode. In every other mode both channels act as compare registers. A select bit may change only while the timer is stopped. While counting, an attempt to change it is ignored, and writing the value it already holds is allowed. A capture channel latches the counter value on a rising edge of its trigger input. A compare channel raises a one-cycle match pulse when the counter equals the value that software wrote.

A small register bus writes the option register as a whole byte or one bit at a time. It writes the compare channels and reads all three registers.

Top module: `ovf_timer`

## Requirements
- R1: After reset the option register reads 0x00, both channel registers read 0, and the overflow flag, interrupt and match pulses are low.
- R2: The counter increments every cycle while countEn is 1 and is held at 0 while countEn is 0, wrapping from 2^CNT_W-1 to 0.
- R3: In mode 0 (free-running) or mode 1 (pulse width), the edge on which the counter wraps sets ovfFlag and raises ovfIrq in the same cycle, and ovfIrq lasts exactly one cycle.
- R4: In modes 2 and 3 a wrap neither sets ovfFlag nor raises ovfIrq.
- R5: Reading the option register does not clear ovfFlag, and writing 1 to bit 0 does not set it.
- R6: Writing 0 to bit 0 clears ovfFlag, through either a byte write or a bit write to bit index 0.
- R7: A cycle with countEn at 0 clears ovfFlag.
- R8: If a clearing write and a wrap that sets the flag fall in the same cycle, ovfFlag is set.
- R9: The option register is at address 0, with bit 0 the flag, bit 4 the channel 0 select and bit 5 the channel 1 select (1 = capture). Bits 1–3, 6 and 7 read 0 and ignore writes. busBitMode=1 writes busWdata[0] to bit busBitIdx.
- R10: While countEn is 1, a write that would change a select bit leaves it unchanged, and a write of its current value is accepted.
- R11: A channel with select 1 in mode 0 loads the pre-edge counter value on a rising edge of its capIn bit and ignores bus writes. Otherwise it acts as compare and takes byte writes at address 1 (channel 0) or 2 (channel 1).
- R12: A compare channel raises its matchPulse bit for one cycle, in the cycle after one in which countEn is 1 and the counter equals the channel value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| countEn | input | 1 | Count enable; 0 stops and clears the counter |
| modeSel | input | 2 | 0 free-running, 1 pulse width, 2/3 other |
| capIn | input | 2 | Capture triggers, one per channel |
| busWe | input | 1 | Register write strobe |
| busBitMode | input | 1 | 1 = single-bit write to the option register |
| busAddr | input | 2 | 0 option, 1 channel 0, 2 channel 1 |
| busBitIdx | input | 3 | Bit index for single-bit writes |
| busWdata | input | CNT_W | Write data |
| busRdata | output | CNT_W | Read data for busAddr |
| chan0 | output | CNT_W | Channel 0 register |
| chan1 | output | CNT_W | Channel 1 register |
| ovfFlag | output | 1 | Sticky overflow flag |
| ovfIrq | output | 1 | One-cycle overflow interrupt |
| matchPulse | output | 2 | One-cycle compare match per channel |

## Verification
A corrupted select bit shows up through busRdata at address 0 on the next read. It also shows up as a wrong capture or match on the next trigger edge or counter pass. A counter that is off by even one shifts the wrap, so ovfFlag and ovfIrq appear a cycle early or late. The next capture loads a value that differs from the model. The bench compares every output against its model on every clock, so any such fault is reported within one counter period at most.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH = 2;
  localparam int SEL_LSB = 4;
  localparam int FLAG_BIT = 0;
  localparam logic [1:0] ADDR_OPT = 2'd0;
  localparam logic [1:0] ADDR_CH0 = 2'd1;
  localparam logic [1:0] MODE_FREE = 2'd0;
  localparam logic [1:0] MODE_PULSE = 2'd1;

  typedef struct packed {
    logic [NUM_CH-1:0] capMode;
    logic [NUM_CH-1:0] chanWr;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              countEn,
  input  logic [1:0]        modeSel,
  input  logic              busWe,
  input  logic              busBitMode,
  input  logic [1:0]        busAddr,
  input  logic [2:0]        busBitIdx,
  input  logic [7:0]        busWbyte,
  input  logic              wrap,
  output logic [7:0]        optReg,
  output logic              ovfFlag,
  output logic              ovfIrq,
  output tmrStrobe_t        strobe
);
  logic [NUM_CH-1:0] selQ;
  logic [NUM_CH-1:0] selD;
  logic flagQ;
  logic irqQ;
  logic clrReq;
  logic ovfEvent;
  logic optHit;
  logic modeCounts;

  assign optHit = busWe && (busAddr == ADDR_OPT);
  assign modeCounts = (modeSel == MODE_FREE) || (modeSel == MODE_PULSE);
  assign ovfEvent = wrap && modeCounts;

  always_comb begin
    clrReq = 1'b0;
    if (optHit) begin
      if (busBitMode) clrReq = (busBitIdx == 3'(FLAG_BIT)) && !busWbyte[0];
      else            clrReq = !busWbyte[FLAG_BIT];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
    logic reqHit;
    logic reqVal;
    always_comb begin
      reqHit = 1'b0;
      reqVal = selQ[ch];
      if (optHit) begin
        if (busBitMode) begin
          reqHit = (busBitIdx == 3'(SEL_LSB + ch));
          reqVal = busWbyte[0];
        end else begin
          reqHit = 1'b1;
          reqVal = busWbyte[SEL_LSB + ch];
        end
      end
      selD[ch] = (reqHit && (!countEn || reqVal == selQ[ch])) ? reqVal : selQ[ch];
    end
    assign strobe.capMode[ch] = selQ[ch] && (modeSel == MODE_FREE);
    assign strobe.chanWr[ch] = busWe && !busBitMode && (busAddr == ADDR_CH0 + 2'(ch));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      flagQ <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      selQ <= selD;
      irqQ <= ovfEvent;
      if (!countEn)      flagQ <= 1'b0;
      else if (ovfEvent) flagQ <= 1'b1;
      else if (clrReq)   flagQ <= 1'b0;
    end
  end

  always_comb begin
    optReg = '0;
    optReg[FLAG_BIT] = flagQ;
    optReg[SEL_LSB +: NUM_CH] = selQ;
  end

  assign ovfFlag = flagQ;
  assign ovfIrq  = irqQ;
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          countEn,
  input  logic [NUM_CH-1:0]             capIn,
  input  logic [CNT_W-1:0]              busWdata,
  input  tmrStrobe_t                    strobe,
  output logic                          wrap,
  output logic [NUM_CH-1:0][CNT_W-1:0]  chanVal,
  output logic [NUM_CH-1:0]             matchPulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;

  assign wrap = countEn && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (countEn) cnt <= cnt + 1'b1;
    else              cnt <= '0;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic capPrev;
    logic capRise;
    logic [CNT_W-1:0] chanQ;
    logic matchQ;

    assign capRise = capIn[ch] && !capPrev;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        capPrev <= 1'b0;
        chanQ   <= '0;
        matchQ  <= 1'b0;
      end else begin
        capPrev <= capIn[ch];
        matchQ  <= !strobe.capMode[ch] && countEn && (cnt == chanQ);
        if (strobe.capMode[ch]) begin
          if (capRise) chanQ <= cnt;
        end else if (strobe.chanWr[ch]) begin
          chanQ <= busWdata;
        end
      end
    end

    assign chanVal[ch] = chanQ;
    assign matchPulse[ch] = matchQ;
  end
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic [1:0]       modeSel,
  input  logic [1:0]       capIn,
  input  logic             busWe,
  input  logic             busBitMode,
  input  logic [1:0]       busAddr,
  input  logic [2:0]       busBitIdx,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] busRdata,
  output logic [CNT_W-1:0] chan0,
  output logic [CNT_W-1:0] chan1,
  output logic             ovfFlag,
  output logic             ovfIrq,
  output logic [1:0]       matchPulse
);
  tmrStrobe_t strobe;
  logic wrap;
  logic [7:0] optReg;
  logic [NUM_CH-1:0][CNT_W-1:0] chanVal;
  logic [NUM_CH-1:0] selBits;

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .countEn(countEn), .modeSel(modeSel),
    .busWe(busWe), .busBitMode(busBitMode), .busAddr(busAddr),
    .busBitIdx(busBitIdx), .busWbyte(busWdata[7:0]), .wrap(wrap),
    .optReg(optReg), .ovfFlag(ovfFlag), .ovfIrq(ovfIrq), .strobe(strobe)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .countEn(countEn), .capIn(capIn),
    .busWdata(busWdata), .strobe(strobe), .wrap(wrap),
    .chanVal(chanVal), .matchPulse(matchPulse)
  );

  assign selBits = optReg[SEL_LSB +: NUM_CH];
  assign chan0 = chanVal[0];
  assign chan1 = chanVal[1];

  always_comb begin
    case (busAddr)
      ADDR_OPT:       busRdata = CNT_W'(optReg);
      ADDR_CH0:       busRdata = chanVal[0];
      ADDR_CH0 + 2'd1: busRdata = chanVal[1];
      default:        busRdata = '0;
    endcase
  end
endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       countEn,
  input logic [1:0] modeSel,
  input logic       ovfFlag,
  input logic       ovfIrq,
  input logic [1:0] selBits,
  input logic [1:0] matchPulse
);
  assert_irq_with_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> ovfFlag);
  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |=> !ovfIrq);
  assert_flag_rise_needs_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> ovfIrq);
  assert_no_irq_other_mode_R4: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> ($past(modeSel) == 2'd0 || $past(modeSel) == 2'd1));
  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    !countEn |=> !ovfFlag);
  assert_sel_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(countEn) |-> $stable(selBits));
  assert_match_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    !countEn |=> matchPulse == 2'b00);
endmodule

bind ovf_timer ovf_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .countEn(countEn), .modeSel(modeSel),
  .ovfFlag(ovfFlag), .ovfIrq(ovfIrq), .selBits(selBits), .matchPulse(matchPulse)
);

// File: tb/ovf_timer_bench.sv
module ovf_timer_bench;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0;
  logic rstN = 0;
  logic countEn = 0;
  logic [1:0] modeSel = 0;
  logic [1:0] capIn = 0;
  logic busWe = 0;
  logic busBitMode = 0;
  logic [1:0] busAddr = 0;
  logic [2:0] busBitIdx = 0;
  logic [W-1:0] busWdata = 0;
  logic [W-1:0] busRdata, chan0, chan1;
  logic ovfFlag, ovfIrq;
  logic [1:0] matchPulse;

  always #4 clk = ~clk;

  ovf_timer #(.CNT_W(W)) u_ovf_timer (
    .clk(clk), .rstN(rstN), .countEn(countEn), .modeSel(modeSel), .capIn(capIn),
    .busWe(busWe), .busBitMode(busBitMode), .busAddr(busAddr), .busBitIdx(busBitIdx),
    .busWdata(busWdata), .busRdata(busRdata), .chan0(chan0), .chan1(chan1),
    .ovfFlag(ovfFlag), .ovfIrq(ovfIrq), .matchPulse(matchPulse)
  );

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";

  // reference state
  int mCnt = 0;
  int mFlag = 0, mIrq = 0;
  int mSel[2] = '{0, 0};
  int mCh[2] = '{0, 0};
  int mPrev[2] = '{0, 0};
  int mMatch[2] = '{0, 0};

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mFlag = 0; mIrq = 0;
      mSel = '{0, 0}; mCh = '{0, 0}; mPrev = '{0, 0}; mMatch = '{0, 0};
    end else begin
      int en, ev, clr, cntOld;
      int selNew[2];
      int capM[2];
      en = countEn;
      cntOld = mCnt;
      ev = (en && mCnt == MAXV && modeSel <= 1) ? 1 : 0;
      clr = 0;
      selNew = mSel;
      if (busWe && busAddr == 0) begin
        if (busBitMode) begin
          if (busBitIdx == 0 && busWdata[0] == 0) clr = 1;
          for (int c = 0; c < 2; c++)
            if (busBitIdx == 4 + c && (!en || busWdata[0] == mSel[c])) selNew[c] = busWdata[0];
        end else begin
          if (busWdata[0] == 0) clr = 1;
          for (int c = 0; c < 2; c++)
            if (!en || busWdata[4 + c] == mSel[c]) selNew[c] = busWdata[4 + c];
        end
      end
      for (int c = 0; c < 2; c++) begin
        capM[c] = (mSel[c] && modeSel == 0) ? 1 : 0;
        mMatch[c] = (!capM[c] && en && cntOld == mCh[c]) ? 1 : 0;
        if (capM[c]) begin
          if (capIn[c] && !mPrev[c]) mCh[c] = cntOld;
        end else if (busWe && !busBitMode && busAddr == 1 + c) begin
          mCh[c] = busWdata;
        end
        mPrev[c] = capIn[c];
      end
      if (!en) mFlag = 0;
      else if (ev) mFlag = 1;
      else if (clr) mFlag = 0;
      mIrq = ev;
      mSel = selNew;
      mCnt = en ? ((mCnt + 1) & MAXV) : 0;
    end
  end

  task automatic cmp(string name, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", curReq, name, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int rd;
    case (busAddr)
      2'd0: rd = mFlag | (mSel[0] << 4) | (mSel[1] << 5);
      2'd1: rd = mCh[0];
      2'd2: rd = mCh[1];
      default: rd = 0;
    endcase
    cmp("busRdata", busRdata, rd);
    cmp("chan0", chan0, mCh[0]);
    cmp("chan1", chan1, mCh[1]);
    cmp("ovfFlag", ovfFlag, mFlag);
    cmp("ovfIrq", ovfIrq, mIrq);
    cmp("match0", matchPulse[0], mMatch[0]);
    cmp("match1", matchPulse[1], mMatch[1]);
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      busWe = 0;
      compareAll();
    end
  endtask

  task automatic wrByte(int addr, int data);
    busWe = 1; busBitMode = 0; busAddr = 2'(addr); busWdata = W'(data);
    tick();
    busAddr = 0;
  endtask

  task automatic wrBit(int idx, int val);
    busWe = 1; busBitMode = 1; busAddr = 0; busBitIdx = 3'(idx); busWdata = W'(val);
    tick();
    busBitMode = 0;
  endtask

  task automatic runToWrapEdge();
    while (mCnt != MAXV) tick();
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    curReq = "R1"; compareAll();
    rstN = 1;
    tick(2);
    busAddr = 1; tick(); busAddr = 2; tick(); busAddr = 0; tick();

    curReq = "R9";
    wrByte(0, 8'hFF); tick();          // sel both 1, reserved ignored
    curReq = "R5"; tick();             // flag stays 0 after writing 1
    curReq = "R9";
    wrBit(4, 0); tick();
    wrBit(2, 1); tick();
    wrBit(7, 1); tick();
    wrByte(0, 8'h10); tick();

    curReq = "R2";
    modeSel = 0; countEn = 1; tick(20);
    curReq = "R11";
    capIn[0] = 1; tick(3); capIn[0] = 0; tick(5);
    wrByte(1, 8'h77); tick();          // ignored in capture mode
    capIn = 2'b11; tick(); capIn = 0; tick(3);

    curReq = "R10";
    wrByte(0, 8'h20); tick(2);         // change refused
    wrBit(4, 0); tick();
    wrByte(0, 8'h10); tick(2);         // same value accepted

    curReq = "R12";
    wrByte(2, 50); tick(3);
    wrByte(2, 120); tick(2);

    curReq = "R3";
    runToWrapEdge(); tick(4);
    curReq = "R5";
    busAddr = 0; tick(5);
    wrBit(0, 1); tick(2);
    wrByte(0, 8'h11); tick(2);
    curReq = "R6";
    wrBit(0, 0); tick(2);
    runToWrapEdge(); tick(3);
    wrByte(0, 8'h10); tick(2);

    curReq = "R8";
    runToWrapEdge();
    busWe = 1; busBitMode = 1; busAddr = 0; busBitIdx = 0; busWdata = 0;
    tick(); busBitMode = 0; tick(3);

    curReq = "R7";
    countEn = 0; tick(3);
    curReq = "R2";
    countEn = 1; tick(10);
    capIn[0] = 1; tick(); capIn[0] = 0; tick(2);

    curReq = "R4";
    countEn = 0; tick(); modeSel = 2; countEn = 1; tick(300);
    curReq = "R11";
    capIn[0] = 1; tick(2); capIn[0] = 0; tick();
    wrByte(1, 30); tick(260);
    curReq = "R4";
    modeSel = 3; tick(270);

    curReq = "R3";
    modeSel = 1; tick(300);
    curReq = "R7";
    countEn = 0; tick(2);
    curReq = "R9";
    wrByte(0, 8'h00); tick(); wrBit(5, 1); tick(); wrBit(5, 0); tick(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule